// File: doc/BRIEF.md
# Nested Trap Entry Sequencer

This block carries out trap entry for a processor that supports several nested trap levels. When a trap request arrives with a trap type, it raises the trap level by one. It saves the interrupted context into a per-level save stack and switches the processor-state word to the global register set that belongs to the class of the trap. It also moves the current window pointer for window-management traps and forms the vector address from the trap base register.

A request made when the level is already at the configured ceiling is refused. In that case the block raises an error flag and leaves every register as it was. A request made one level below the ceiling is still taken, but it also forces the reduced-state bit.

The surrounding core supplies the current architectural values and pulses `trap_valid_i`. One cycle later it takes the updated values from the registered outputs, where `done_o` marks them valid. The save stack can be read at any level through a combinational read port.

Top module: `trap_entry_seq`

## Requirements
- R1: A request with `tl_i` at or above the effective ceiling (the smaller of `max_tl_i` and MAX_TL) raises `err_o`. In that case `tl_o`, `pstate_o`, `cwp_o`, `pc_o` and `npc_o` return the inputs unchanged, and no save-stack slot is written.
- R2: A request with `tl_i` more than one below the effective ceiling yields `tl_o = tl_i + 1` and leaves the reduced-state bit (pstate bit 5) as it came in.
- R3: A request with `tl_i` exactly one below the effective ceiling yields `tl_o = tl_i + 1` and sets pstate bit 5.
- R4: A taken trap writes save-stack slot `tl_o` (slots 1..MAX_TL) with four values: the trap type, `pc_i`, `npc_i`, and a 40-bit context word. The context word holds `ccr_i` in bits 39:32, `asi_i` in bits 31:24, the pstate after R3 masked with 0xF3F in bits 19:8, and `cwp_i` in bits 7:0. Reading level 0 returns zero.
- R5: In the new pstate, exactly one global-select bit is set. Bit 11 is set for trap type 0x060. Bit 10 is set for types 0x008 and 0x030 and for the ranges 0x064..0x06F. Bit 0 is set for every other type. Bits 2 and 4 are always set, and all other bits pass through.
- R6: Trap type 0x024 gives `cwp_o = (cwp_i - 1) mod NWIN`.
- R7: A type whose bits 8:6 equal 3'b010 gives `cwp_o = (cwp_i - cansave_i - 2) mod NWIN`. A type whose bits 8:6 equal 3'b011 gives `cwp_o = (cwp_i + 1) mod NWIN`. Any other type not covered by R6 leaves `cwp_o = cwp_i`.
- R8: For a taken trap, `pc_o` is formed from four parts: `tba_i` bits above 14; bit 14 set when the new level exceeds 1; the trap type in bits 13:5; and bits 4:0 cleared. `npc_o = pc_o + 4`.
- R9: `done_o` is high for exactly the one cycle after each cycle in which `trap_valid_i` is high, and the outputs are valid in that cycle.
- R10: After reset, all outputs and all save-stack slots are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_valid_i | input | 1 | Trap request strobe |
| tt_i | input | 9 | Trap type |
| ccr_i | input | 8 | Condition codes |
| asi_i | input | 8 | Current address space identifier |
| pstate_i | input | 12 | Current processor-state word |
| cwp_i | input | CWP_W | Current window pointer |
| cansave_i | input | CWP_W | Count of windows free to save |
| tl_i | input | TL_W | Current trap level |
| max_tl_i | input | TL_W | Trap level ceiling |
| pc_i | input | PC_W | Program counter at the trap |
| npc_i | input | PC_W | Next program counter at the trap |
| tba_i | input | PC_W | Trap base register |
| rd_lvl_i | input | TL_W | Save-stack read level |
| tl_o | output | TL_W | New trap level |
| pstate_o | output | 12 | New processor-state word |
| cwp_o | output | CWP_W | New window pointer |
| pc_o | output | PC_W | Vector address |
| npc_o | output | PC_W | Vector address plus 4 |
| done_o | output | 1 | Result valid strobe |
| err_o | output | 1 | Request refused at ceiling |
| rd_tstate_o | output | 40 | Saved context word at `rd_lvl_i` |
| rd_tpc_o | output | PC_W | Saved PC at `rd_lvl_i` |
| rd_tnpc_o | output | PC_W | Saved NPC at `rd_lvl_i` |
| rd_tt_o | output | 9 | Saved trap type at `rd_lvl_i` |

## Verification
Saturation into the reduced state can fall in the same cycle as a window move and a global-set switch. This happens when a spill, fill, clean-window or fault trap arrives at the level just below the ceiling. The sweep crosses every level, including those at and past the ceiling, with every ceiling value and a list of trap types that covers each class boundary. This makes those coincidences occur many times. Each one is judged in three places: the saved context word must already hold the reduced-state bit, the new pstate must carry both the reduced-state bit and the class's global bit, and the vector must carry the level-above-one bit.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

   localparam int TT_W     = 9;
   localparam int PS_W     = 12;
   localparam int TSTATE_W = 40;

   // trap type codes the sequencer decodes
   localparam logic [TT_W-1:0] TT_IVEC    = 9'h060;
   localparam logic [TT_W-1:0] TT_IFAULT  = 9'h008;
   localparam logic [TT_W-1:0] TT_DFAULT  = 9'h030;
   localparam logic [TT_W-1:0] TT_IMISS   = 9'h064;
   localparam logic [TT_W-1:0] TT_DMISS   = 9'h068;
   localparam logic [TT_W-1:0] TT_DPROT   = 9'h06C;
   localparam logic [TT_W-1:0] TT_CLEAN   = 9'h024;
   localparam logic [TT_W-1:0] TT_SPILL   = 9'h080;
   localparam logic [TT_W-1:0] TT_FILL    = 9'h0C0;
   localparam logic [TT_W-1:0] TT_WG_MASK = 9'h1C0;

   // processor-state bit positions
   localparam int PS_AG   = 0;
   localparam int PS_PRIV = 2;
   localparam int PS_PEF  = 4;
   localparam int PS_RED  = 5;
   localparam int PS_MG   = 10;
   localparam int PS_IG   = 11;
   localparam logic [PS_W-1:0] PS_SAVE_MASK = 12'hF3F;

   typedef enum logic [1:0] {GSEL_ALT, GSEL_MMU, GSEL_INT} gsel_e;
   typedef enum logic [1:0] {WMOVE_NONE, WMOVE_CLEAN, WMOVE_SPILL, WMOVE_FILL} wmove_e;

endpackage

// File: rtl/trap_class_dec.sv
module trap_class_dec
   import trap_entry_pkg::*;
(
   input  logic [TT_W-1:0] tt_i,
   output gsel_e           gsel_o,
   output wmove_e          wmove_o
);

   logic is_mmu;

   always_comb begin
      is_mmu = (tt_i == TT_IFAULT) || (tt_i == TT_DFAULT) ||
               (tt_i[TT_W-1:2] == TT_IMISS[TT_W-1:2]) ||
               (tt_i[TT_W-1:2] == TT_DMISS[TT_W-1:2]) ||
               (tt_i[TT_W-1:2] == TT_DPROT[TT_W-1:2]);
      if (tt_i == TT_IVEC)
         gsel_o = GSEL_INT;
      else if (is_mmu)
         gsel_o = GSEL_MMU;
      else
         gsel_o = GSEL_ALT;
   end

   always_comb begin
      if (tt_i == TT_CLEAN)
         wmove_o = WMOVE_CLEAN;
      else if ((tt_i & TT_WG_MASK) == TT_SPILL)
         wmove_o = WMOVE_SPILL;
      else if ((tt_i & TT_WG_MASK) == TT_FILL)
         wmove_o = WMOVE_FILL;
      else
         wmove_o = WMOVE_NONE;
   end

endmodule

// File: rtl/trap_level_ctl.sv
module trap_level_ctl #(
   parameter int MAX_TL = 5,
   parameter int TL_W   = 3
) (
   input  logic [TL_W-1:0] tl_i,
   input  logic [TL_W-1:0] max_tl_i,
   output logic            fault_o,
   output logic            set_red_o,
   output logic [TL_W-1:0] tl_next_o
);

   localparam logic [TL_W-1:0] DEPTH = TL_W'(MAX_TL);

   logic [TL_W-1:0] eff_max;
   logic [TL_W:0]   tl_plus;

   always_comb begin
      eff_max   = (max_tl_i > DEPTH) ? DEPTH : max_tl_i;
      fault_o   = (tl_i >= eff_max);
      tl_plus   = {1'b0, tl_i} + {{TL_W{1'b0}}, 1'b1};
      set_red_o = !fault_o && (tl_plus == {1'b0, eff_max});
      tl_next_o = fault_o ? tl_i : tl_plus[TL_W-1:0];
   end

endmodule

// File: rtl/trap_window_rot.sv
module trap_window_rot
   import trap_entry_pkg::*;
#(
   parameter int NWIN  = 8,
   parameter int CWP_W = 3
) (
   input  logic [CWP_W-1:0] cwp_i,
   input  logic [CWP_W-1:0] cansave_i,
   input  wmove_e           wmove_i,
   output logic [CWP_W-1:0] cwp_o
);

   localparam bit POW2 = (NWIN == (1 << CWP_W));

   generate
      if (POW2) begin : g_wrap
         always_comb begin
            unique case (wmove_i)
               WMOVE_CLEAN: cwp_o = cwp_i - CWP_W'(1);
               WMOVE_SPILL: cwp_o = cwp_i - cansave_i - CWP_W'(2);
               WMOVE_FILL:  cwp_o = cwp_i + CWP_W'(1);
               default:     cwp_o = cwp_i;
            endcase
         end
      end else begin : g_modulo
         int step;
         int sum;
         always_comb begin
            unique case (wmove_i)
               WMOVE_CLEAN: step = NWIN - 1;
               WMOVE_SPILL: step = 2 * NWIN - (int'(cansave_i) % NWIN) - 2;
               WMOVE_FILL:  step = 1;
               default:     step = 0;
            endcase
            sum   = int'(cwp_i) + step;
            cwp_o = CWP_W'(sum % NWIN);
         end
      end
   endgenerate

endmodule

// File: rtl/trap_state_stack.sv
module trap_state_stack #(
   parameter int DEPTH = 5,
   parameter int TL_W  = 3,
   parameter int PC_W  = 64,
   parameter int TS_W  = 40,
   parameter int TT_W  = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en_i,
   input  logic [TL_W-1:0] wr_lvl_i,
   input  logic [TS_W-1:0] wr_tstate_i,
   input  logic [PC_W-1:0] wr_pc_i,
   input  logic [PC_W-1:0] wr_npc_i,
   input  logic [TT_W-1:0] wr_tt_i,
   input  logic [TL_W-1:0] rd_lvl_i,
   output logic [TS_W-1:0] rd_tstate_o,
   output logic [PC_W-1:0] rd_pc_o,
   output logic [PC_W-1:0] rd_npc_o,
   output logic [TT_W-1:0] rd_tt_o
);

   logic [TS_W-1:0] ts_q  [DEPTH];
   logic [PC_W-1:0] pc_q  [DEPTH];
   logic [PC_W-1:0] npc_q [DEPTH];
   logic [TT_W-1:0] tt_q  [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ts_q[g]  <= '0;
            pc_q[g]  <= '0;
            npc_q[g] <= '0;
            tt_q[g]  <= '0;
         end else if (wr_en_i && (wr_lvl_i == TL_W'(g + 1))) begin
            ts_q[g]  <= wr_tstate_i;
            pc_q[g]  <= wr_pc_i;
            npc_q[g] <= wr_npc_i;
            tt_q[g]  <= wr_tt_i;
         end
      end
   end

   always_comb begin
      rd_tstate_o = '0;
      rd_pc_o     = '0;
      rd_npc_o    = '0;
      rd_tt_o     = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (rd_lvl_i == TL_W'(k + 1)) begin
            rd_tstate_o = ts_q[k];
            rd_pc_o     = pc_q[k];
            rd_npc_o    = npc_q[k];
            rd_tt_o     = tt_q[k];
         end
      end
   end

   // R4: a write always targets a real slot, never level zero
   a_r4_slot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |-> (wr_lvl_i != '0) && (wr_lvl_i <= TL_W'(DEPTH)));

endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
   import trap_entry_pkg::*;
#(
   parameter int MAX_TL = 5,
   parameter int NWIN   = 8,
   parameter int PC_W   = 64,
   parameter int TL_W   = $clog2(MAX_TL + 1),
   parameter int CWP_W  = $clog2(NWIN)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                trap_valid_i,
   input  logic [TT_W-1:0]     tt_i,
   input  logic [7:0]          ccr_i,
   input  logic [7:0]          asi_i,
   input  logic [PS_W-1:0]     pstate_i,
   input  logic [CWP_W-1:0]    cwp_i,
   input  logic [CWP_W-1:0]    cansave_i,
   input  logic [TL_W-1:0]     tl_i,
   input  logic [TL_W-1:0]     max_tl_i,
   input  logic [PC_W-1:0]     pc_i,
   input  logic [PC_W-1:0]     npc_i,
   input  logic [PC_W-1:0]     tba_i,
   input  logic [TL_W-1:0]     rd_lvl_i,
   output logic [TL_W-1:0]     tl_o,
   output logic [PS_W-1:0]     pstate_o,
   output logic [CWP_W-1:0]    cwp_o,
   output logic [PC_W-1:0]     pc_o,
   output logic [PC_W-1:0]     npc_o,
   output logic                done_o,
   output logic                err_o,
   output logic [TSTATE_W-1:0] rd_tstate_o,
   output logic [PC_W-1:0]     rd_tpc_o,
   output logic [PC_W-1:0]     rd_tnpc_o,
   output logic [TT_W-1:0]     rd_tt_o
);

   localparam int VEC_LO = 5;
   localparam int VEC_HI = 14;

   generate
      if (MAX_TL < 2) begin : g_bad_tl
         $error("trap_entry_seq: MAX_TL below 2");
      end
      if (NWIN < 3) begin : g_bad_nwin
         $error("trap_entry_seq: NWIN below 3");
      end
      if (CWP_W > 8) begin : g_bad_cwp
         $error("trap_entry_seq: window pointer wider than its context field");
      end
      if (PC_W < VEC_HI + 2) begin : g_bad_pc
         $error("trap_entry_seq: PC_W too narrow for the vector layout");
      end
   endgenerate

   logic             lvl_fault;
   logic             set_red;
   logic [TL_W-1:0]  tl_next;
   gsel_e            gsel;
   wmove_e           wmove;
   logic [CWP_W-1:0] cwp_next;
   logic [PS_W-1:0]  ps_marked;
   logic [PS_W-1:0]  ps_next;
   logic [TSTATE_W-1:0] tstate_w;
   logic [PC_W-1:0]  vec_pc;
   logic             take;

   trap_level_ctl #(.MAX_TL(MAX_TL), .TL_W(TL_W)) u_level (
      .tl_i      (tl_i),
      .max_tl_i  (max_tl_i),
      .fault_o   (lvl_fault),
      .set_red_o (set_red),
      .tl_next_o (tl_next)
   );

   trap_class_dec u_class (
      .tt_i    (tt_i),
      .gsel_o  (gsel),
      .wmove_o (wmove)
   );

   trap_window_rot #(.NWIN(NWIN), .CWP_W(CWP_W)) u_window (
      .cwp_i     (cwp_i),
      .cansave_i (cansave_i),
      .wmove_i   (wmove),
      .cwp_o     (cwp_next)
   );

   always_comb begin
      ps_marked = pstate_i;
      if (set_red) ps_marked[PS_RED] = 1'b1;
      ps_next = ps_marked;
      ps_next[PS_AG] = 1'b0;
      ps_next[PS_MG] = 1'b0;
      ps_next[PS_IG] = 1'b0;
      unique case (gsel)
         GSEL_INT: ps_next[PS_IG] = 1'b1;
         GSEL_MMU: ps_next[PS_MG] = 1'b1;
         default:  ps_next[PS_AG] = 1'b1;
      endcase
      ps_next[PS_PRIV] = 1'b1;
      ps_next[PS_PEF]  = 1'b1;
   end

   assign tstate_w = {ccr_i, asi_i, 4'b0000, ps_marked & PS_SAVE_MASK, 8'(cwp_i)};
   assign vec_pc   = {tba_i[PC_W-1:VEC_HI+1], (tl_next > TL_W'(1)), tt_i, {VEC_LO{1'b0}}};
   assign take     = trap_valid_i && !lvl_fault;

   trap_state_stack #(
      .DEPTH (MAX_TL),
      .TL_W  (TL_W),
      .PC_W  (PC_W),
      .TS_W  (TSTATE_W),
      .TT_W  (TT_W)
   ) u_stack (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en_i     (take),
      .wr_lvl_i    (tl_next),
      .wr_tstate_i (tstate_w),
      .wr_pc_i     (pc_i),
      .wr_npc_i    (npc_i),
      .wr_tt_i     (tt_i),
      .rd_lvl_i    (rd_lvl_i),
      .rd_tstate_o (rd_tstate_o),
      .rd_pc_o     (rd_tpc_o),
      .rd_npc_o    (rd_tnpc_o),
      .rd_tt_o     (rd_tt_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tl_o     <= '0;
         pstate_o <= '0;
         cwp_o    <= '0;
         pc_o     <= '0;
         npc_o    <= '0;
         done_o   <= 1'b0;
         err_o    <= 1'b0;
      end else begin
         done_o <= trap_valid_i;
         err_o  <= trap_valid_i && lvl_fault;
         if (trap_valid_i) begin
            if (lvl_fault) begin
               tl_o     <= tl_i;
               pstate_o <= pstate_i;
               cwp_o    <= cwp_i;
               pc_o     <= pc_i;
               npc_o    <= npc_i;
            end else begin
               tl_o     <= tl_next;
               pstate_o <= ps_next;
               cwp_o    <= cwp_next;
               pc_o     <= vec_pc;
               npc_o    <= vec_pc + PC_W'(4);
            end
         end
      end
   end

   // R1: a refused request keeps the level
   a_r1_fault_holds_level: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid_i && lvl_fault) |=> (err_o && tl_o == $past(tl_i)));

   // R2: a taken request steps the level by one
   a_r2_level_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_valid_i && !lvl_fault) |=> (!err_o && tl_o == $past(tl_i) + TL_W'(1)));

   // R5: a taken trap leaves exactly one global set selected
   a_r5_one_global: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !err_o) |-> ($countones({pstate_o[PS_IG], pstate_o[PS_MG], pstate_o[PS_AG]}) == 1));

   // R8: vector pair is consecutive
   a_r8_npc_next: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !err_o) |-> (npc_o == pc_o + PC_W'(4)));

   // R9: result strobe follows every request
   a_r9_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
      trap_valid_i |=> done_o);

   // R9: no strobe without a request
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_valid_i |=> !done_o);

endmodule

// File: tb/trap_entry_seq_test.sv
`timescale 1ns/1ps
module trap_entry_seq_test;

   localparam int MAXL = 5;
   localparam int NW   = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trap_valid_i = 1'b0;
   logic [8:0]  tt_i = '0;
   logic [7:0]  ccr_i = '0;
   logic [7:0]  asi_i = '0;
   logic [11:0] pstate_i = '0;
   logic [2:0]  cwp_i = '0;
   logic [2:0]  cansave_i = '0;
   logic [2:0]  tl_i = '0;
   logic [2:0]  max_tl_i = '0;
   logic [63:0] pc_i = '0;
   logic [63:0] npc_i = '0;
   logic [63:0] tba_i = '0;
   logic [2:0]  rd_lvl_i = '0;
   logic [2:0]  tl_o;
   logic [11:0] pstate_o;
   logic [2:0]  cwp_o;
   logic [63:0] pc_o;
   logic [63:0] npc_o;
   logic        done_o;
   logic        err_o;
   logic [39:0] rd_tstate_o;
   logic [63:0] rd_tpc_o;
   logic [63:0] rd_tnpc_o;
   logic [8:0]  rd_tt_o;

   int n_run  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [39:0] m_ts  [8];
   logic [63:0] m_pc  [8];
   logic [63:0] m_npc [8];
   logic [8:0]  m_tt  [8];

   localparam logic [8:0] TTL [17] = '{
      9'h060, 9'h008, 9'h030, 9'h064, 9'h067, 9'h06B, 9'h06C, 9'h06F,
      9'h024, 9'h080, 9'h0BC, 9'h0C0, 9'h0FF, 9'h010, 9'h041, 9'h100, 9'h1C0};

   trap_entry_seq uut (.*);

   always #2.5 clk = ~clk;

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic one_trap(input int tl, input int mx, input logic [8:0] tt, input int idx);
      logic [11:0] ps, ps_sv, ps_nx;
      logic [39:0] ts;
      logic [63:0] vec;
      int ntl, ecwp, cs;
      bit fault, red, mmu;
      cs = (idx / 8) % 7;
      @(negedge clk);
      tt_i      = tt;
      tl_i      = 3'(tl);
      max_tl_i  = 3'(mx);
      ccr_i     = 8'(idx * 13 + 1);
      asi_i     = 8'(idx * 7 + 3);
      pstate_i  = 12'(12'hA5A ^ (idx * 37));
      cwp_i     = 3'(idx % 8);
      cansave_i = 3'(cs);
      pc_i      = 64'h0000_1000_0000_0000 + 64'(idx) * 4;
      npc_i     = pc_i + 64'd8;
      tba_i     = 64'hFFFF_F000_1234_5678 ^ (64'(idx) << 20);
      trap_valid_i = 1'b1;
      @(negedge clk);
      trap_valid_i = 1'b0;
      fault = (tl >= mx);
      chk("R9", "done", 64'(done_o), 64'd1);
      if (fault) begin
         chk("R1", "err", 64'(err_o), 64'd1);
         chk("R1", "tl", 64'(tl_o), 64'(tl));
         chk("R1", "pstate", 64'(pstate_o), 64'(pstate_i));
         chk("R1", "cwp", 64'(cwp_o), 64'(cwp_i));
         chk("R1", "pc", pc_o, pc_i);
         chk("R1", "npc", npc_o, npc_i);
         rd_lvl_i = 3'(mx);
         #1;
         chk("R1", "stack tt untouched", 64'(rd_tt_o), 64'(m_tt[mx]));
         chk("R1", "stack pc untouched", rd_tpc_o, m_pc[mx]);
      end else begin
         ntl = tl + 1;
         red = (tl == mx - 1);
         ps = pstate_i;
         if (red) ps[5] = 1'b1;
         ps_sv = ps & 12'hF3F;
         mmu = (tt == 9'h008) || (tt == 9'h030) || (tt >= 9'h064 && tt <= 9'h06F);
         ps_nx = ps & ~12'hC01;
         if (tt == 9'h060) ps_nx[11] = 1'b1;
         else if (mmu) ps_nx[10] = 1'b1;
         else ps_nx[0] = 1'b1;
         ps_nx = ps_nx | 12'h014;
         if (tt == 9'h024) ecwp = (idx % 8 + NW - 1) % NW;
         else if (tt[8:6] == 3'b010) ecwp = (idx % 8 + 2 * NW - cs - 2) % NW;
         else if (tt[8:6] == 3'b011) ecwp = (idx % 8 + 1) % NW;
         else ecwp = idx % 8;
         ts  = {ccr_i, asi_i, 4'b0, ps_sv, 5'b0, cwp_i};
         vec = (tba_i & ~64'h7FFF) | ((ntl > 1) ? 64'h4000 : 64'h0) | (64'(tt) << 5);
         chk("R1", "err low", 64'(err_o), 64'd0);
         chk(red ? "R3" : "R2", "tl", 64'(tl_o), 64'(ntl));
         chk(red ? "R3" : "R2", "red bit", 64'(pstate_o[5]), red ? 64'd1 : 64'(pstate_i[5]));
         chk("R5", "pstate", 64'(pstate_o), 64'(ps_nx));
         chk((tt == 9'h024) ? "R6" : "R7", "cwp", 64'(cwp_o), 64'(ecwp));
         chk("R8", "pc", pc_o, vec);
         chk("R8", "npc", npc_o, vec + 64'd4);
         rd_lvl_i = 3'(ntl);
         #1;
         chk("R4", "context word", 64'(rd_tstate_o), 64'(ts));
         chk("R4", "saved pc", rd_tpc_o, pc_i);
         chk("R4", "saved npc", rd_tnpc_o, npc_i);
         chk("R4", "saved tt", 64'(rd_tt_o), 64'(tt));
         m_ts[ntl] = ts; m_pc[ntl] = pc_i; m_npc[ntl] = npc_i; m_tt[ntl] = tt;
      end
      @(negedge clk);
      chk("R9", "done drops", 64'(done_o), 64'd0);
      chk("R9", "err drops", 64'(err_o), 64'd0);
   endtask

   initial begin
      int idx;
      for (int i = 0; i < 8; i++) begin
         m_ts[i] = '0; m_pc[i] = '0; m_npc[i] = '0; m_tt[i] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd_lvl_i = 3'd1;
      #1;
      chk("R10", "tl", 64'(tl_o), 64'd0);
      chk("R10", "pstate", 64'(pstate_o), 64'd0);
      chk("R10", "pc", pc_o, 64'd0);
      chk("R10", "done", 64'(done_o), 64'd0);
      chk("R10", "err", 64'(err_o), 64'd0);
      chk("R10", "stack slot", 64'(rd_tstate_o), 64'd0);
      idx = 0;
      for (int tl = 0; tl < 7; tl++)
         for (int mx = 2; mx <= MAXL; mx++)
            for (int k = 0; k < 17; k++) begin
               one_trap(tl, mx, TTL[k], idx);
               idx++;
            end
      rd_lvl_i = 3'd0;
      #1;
      chk("R4", "level zero read", 64'(rd_tt_o), 64'd0);
      chk("R4", "level zero pc", rd_tpc_o, 64'd0);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule